// File: doc/BRIEF.md
# Multiplexed External Memory Bridge

This block sits between a core's 16-bit data-space bus and a byte-wide external SRAM. The SRAM is reached over two pin groups. One is an 8-bit port that first carries the low address byte and then the data byte. The other is an 8-bit port that carries the high address byte. An address-latch strobe marks the address phase, so an external transparent latch can hold the low byte while the shared port switches to data. The bridge decodes every bus address. Register-file, I/O-space and on-chip SRAM addresses raise a select line and complete in the same cycle. Only addresses above the on-chip SRAM go off-chip.

The sequencer is an enumerated state machine with four states:
- `XS_IDLE` waits for a request.
- `XS_ADDR` drives the address and the latch strobe.
- `XS_DATA` asserts the active-low read or write strobe.
- `XS_HOLD` is an optional stretch cycle.

The transitions are:
- `XS_IDLE → XS_ADDR` on an accepted off-chip request.
- `XS_ADDR → XS_DATA` always.
- `XS_DATA → XS_HOLD` when the wait bit was set at acceptance.
- `XS_DATA → XS_IDLE` when the wait bit was clear.
- `XS_HOLD → XS_IDLE` always.

While the external mode is off, the two pin groups carry general-purpose I/O values from the port logic. The mode enable is bit 7 of the MCU control register and the wait enable is bit 6; both arrive as single-bit inputs.

Top module: `xmem_bridge`

## Requirements
- R1: After reset, `ale` is 0, `rd_n` and `wr_n` are 1 and `bus_ready` is 0 while no request is pending.
- R2: A request raises exactly one select in the same cycle, together with `bus_ready`, and produces no `ale` and no strobe. `sel_regs` covers 0x0000–0x001F, `sel_io` covers 0x0020–0x005F and `sel_sram` covers 0x0060–0x015F.
- R3: An external cycle starts only for addresses above 0x015F while `xmem_enable` (control bit 7) is 1.
- R4: While `xmem_enable` is 0 and no external cycle is active, `ad_out`/`ad_oe` follow `gp_a_out`/`gp_a_oe` and `ahi_out`/`ahi_oe` follow `gp_c_out`/`gp_c_oe`. A request above 0x015F then completes in the same cycle with `bus_rdata` = 0 and no strobe.
- R5: In the cycle after an off-chip request is accepted, `ale` is 1 for exactly one cycle, `ad_out` holds the low address byte and `ad_oe` is all ones.
- R6: `ahi_out` carries the high address byte with `ahi_oe` all ones from the address phase through the last data-phase cycle.
- R7: In a write data phase, `wr_n` is 0, `rd_n` is 1, and `ad_out` equals the write byte with `ad_oe` all ones. `rd_n` and `wr_n` are never both 0.
- R8: In a read data phase, `rd_n` is 0 and `ad_oe` is 0. In the final data cycle `bus_rdata` equals `ad_in`.
- R9: With `xmem_wait` (control bit 6) set at acceptance, the data phase lasts two cycles with the strobe low in both. Otherwise it lasts one cycle.
- R10: `bus_ready` is 0 from acceptance until the final data cycle, is 1 in that cycle only, and both strobes are 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Core data-space access request, held until ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Data-space byte address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte from external memory |
| bus_ready | output | 1 | Access completes in this cycle |
| sel_regs | output | 1 | Register-file access select |
| sel_io | output | 1 | I/O-space access select |
| sel_sram | output | 1 | On-chip SRAM access select |
| xmem_enable | input | 1 | External memory mode (control bit 7) |
| xmem_wait | input | 1 | Insert stretch cycle (control bit 6) |
| gp_a_out | input | 8 | General I/O value for the shared port |
| gp_a_oe | input | 8 | General I/O enables for the shared port |
| gp_c_out | input | 8 | General I/O value for the high-address port |
| gp_c_oe | input | 8 | General I/O enables for the high-address port |
| ad_out | output | 8 | Shared address/data port value |
| ad_oe | output | 8 | Shared port per-bit output enable |
| ad_in | input | 8 | Shared port pin input |
| ahi_out | output | 8 | High address port value |
| ahi_oe | output | 8 | High address port output enable |
| ale | output | 1 | Address-latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
Cycle 0 is the cycle in which the bench presents a request. Internal accesses and disabled off-chip accesses assert ready and their select in cycle 0. An off-chip access shows the latch strobe and the address bytes in cycle 1 and the data strobe in cycle 2. Ready arrives in cycle 2, or in cycle 3 with the wait bit. Both strobes are high in the cycle after ready. The bench drives inputs and samples outputs one step after each falling edge, and counts falling edges from the request so that every check lands in the cycle that is due. A behavioural latch and memory connected to the pins let the written bytes be read back through later accesses.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    // Sequencer phases of one off-chip access
    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_ADDR = 2'd1,
        XS_DATA = 2'd2,
        XS_HOLD = 2'd3
    } xs_state_e;

    // Data-space region of an address
    typedef enum logic [1:0] {
        RG_REGS = 2'd0,
        RG_IO   = 2'd1,
        RG_SRAM = 2'd2,
        RG_EXT  = 2'd3
    } region_e;

endpackage

// File: rtl/xmem_decode.sv
module xmem_decode
    import xmem_pkg::*;
#(
    parameter int AW        = 16,
    parameter int REG_LAST  = 'h1F,
    parameter int IO_LAST   = 'h5F,
    parameter int SRAM_LAST = 'h15F
) (
    input  logic [AW-1:0] addr,
    output region_e       region
);

    localparam logic [AW-1:0] L_REG  = AW'(REG_LAST);
    localparam logic [AW-1:0] L_IO   = AW'(IO_LAST);
    localparam logic [AW-1:0] L_SRAM = AW'(SRAM_LAST);

    always_comb begin
        if (addr <= L_REG)       region = RG_REGS;
        else if (addr <= L_IO)   region = RG_IO;
        else if (addr <= L_SRAM) region = RG_SRAM;
        else                     region = RG_EXT;
    end

endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          we_in,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] wdata_in,
    input  logic          stretch_in,
    output xs_state_e     state,
    output logic          cmd_we,
    output logic [AW-1:0] cmd_addr,
    output logic [DW-1:0] cmd_wdata,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic          drive_addr,
    output logic          drive_data,
    output logic          busy,
    output logic          last
);

    xs_state_e state_nx;
    logic      cmd_stretch;

    // State register and command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= XS_IDLE;
            cmd_we      <= 1'b0;
            cmd_addr    <= '0;
            cmd_wdata   <= '0;
            cmd_stretch <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == XS_IDLE && start) begin
                cmd_we      <= we_in;
                cmd_addr    <= addr_in;
                cmd_wdata   <= wdata_in;
                cmd_stretch <= stretch_in;
            end
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            XS_IDLE: if (start) state_nx = XS_ADDR;
            XS_ADDR: state_nx = XS_DATA;
            XS_DATA: state_nx = cmd_stretch ? XS_HOLD : XS_IDLE;
            XS_HOLD: state_nx = XS_IDLE;
        endcase
    end

    // Outputs per state
    always_comb begin
        ale        = 1'b0;
        rd_n       = 1'b1;
        wr_n       = 1'b1;
        drive_addr = 1'b0;
        drive_data = 1'b0;
        busy       = 1'b1;
        last       = 1'b0;
        unique case (state)
            XS_IDLE: busy = 1'b0;
            XS_ADDR: begin
                ale        = 1'b1;
                drive_addr = 1'b1;
            end
            XS_DATA: begin
                rd_n       = cmd_we;
                wr_n       = !cmd_we;
                drive_data = cmd_we;
                last       = !cmd_stretch;
            end
            XS_HOLD: begin
                rd_n       = cmd_we;
                wr_n       = !cmd_we;
                drive_data = cmd_we;
                last       = 1'b1;
            end
        endcase
    end

    // R5: latch strobe lasts one cycle
    p_ale_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R5: a data strobe follows the latch strobe
    p_addr_then_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!rd_n || !wr_n));

    // R7: never both strobes
    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R9: stretch cycle follows a data cycle with the same strobe
    p_hold_after_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == XS_HOLD) |-> ($past(state) == XS_DATA && $stable(rd_n) && $stable(wr_n)));

endmodule

// File: rtl/xmem_pins.sv
module xmem_pins #(
    parameter int DW = 8,
    parameter int HW = 8
) (
    input  logic          own_bus,
    input  logic          drive_addr,
    input  logic          drive_data,
    input  logic          busy,
    input  logic [DW-1:0] addr_lo,
    input  logic [HW-1:0] addr_hi,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] gp_a_out,
    input  logic [DW-1:0] gp_a_oe,
    input  logic [HW-1:0] gp_c_out,
    input  logic [HW-1:0] gp_c_oe,
    output logic [DW-1:0] ad_out,
    output logic [DW-1:0] ad_oe,
    output logic [HW-1:0] ahi_out,
    output logic [HW-1:0] ahi_oe
);

    always_comb begin
        if (!own_bus) begin
            ad_out  = gp_a_out;
            ad_oe   = gp_a_oe;
            ahi_out = gp_c_out;
            ahi_oe  = gp_c_oe;
        end else begin
            ahi_out = busy ? addr_hi : '0;
            ahi_oe  = busy ? '1 : '0;
            if (drive_addr) begin
                ad_out = addr_lo;
                ad_oe  = '1;
            end else if (drive_data) begin
                ad_out = wdata;
                ad_oe  = '1;
            end else begin
                ad_out = '0;
                ad_oe  = '0;
            end
        end
    end

endmodule

// File: rtl/xmem_bridge.sv
module xmem_bridge
    import xmem_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 8,
    parameter int REG_LAST  = 'h1F,
    parameter int IO_LAST   = 'h5F,
    parameter int SRAM_LAST = 'h15F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_req,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_ready,
    output logic          sel_regs,
    output logic          sel_io,
    output logic          sel_sram,
    input  logic          xmem_enable,
    input  logic          xmem_wait,
    input  logic [DW-1:0] gp_a_out,
    input  logic [DW-1:0] gp_a_oe,
    input  logic [AW-DW-1:0] gp_c_out,
    input  logic [AW-DW-1:0] gp_c_oe,
    output logic [DW-1:0] ad_out,
    output logic [DW-1:0] ad_oe,
    input  logic [DW-1:0] ad_in,
    output logic [AW-DW-1:0] ahi_out,
    output logic [AW-DW-1:0] ahi_oe,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n
);

    localparam int HW = AW - DW;

    region_e       region;
    xs_state_e     state;
    logic          start, idle_req;
    logic          cmd_we, drive_addr, drive_data, busy, last;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_wdata;

    xmem_decode #(
        .AW(AW), .REG_LAST(REG_LAST), .IO_LAST(IO_LAST), .SRAM_LAST(SRAM_LAST)
    ) u_decode (
        .addr   (bus_addr),
        .region (region)
    );

    assign idle_req = bus_req && (state == XS_IDLE);
    assign start    = idle_req && xmem_enable && (region == RG_EXT);

    xmem_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .we_in      (bus_we),
        .addr_in    (bus_addr),
        .wdata_in   (bus_wdata),
        .stretch_in (xmem_wait),
        .state      (state),
        .cmd_we     (cmd_we),
        .cmd_addr   (cmd_addr),
        .cmd_wdata  (cmd_wdata),
        .ale        (ale),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .drive_addr (drive_addr),
        .drive_data (drive_data),
        .busy       (busy),
        .last       (last)
    );

    xmem_pins #(.DW(DW), .HW(HW)) u_pins (
        .own_bus    (xmem_enable || busy),
        .drive_addr (drive_addr),
        .drive_data (drive_data),
        .busy       (busy),
        .addr_lo    (cmd_addr[DW-1:0]),
        .addr_hi    (cmd_addr[AW-1:DW]),
        .wdata      (cmd_wdata),
        .gp_a_out   (gp_a_out),
        .gp_a_oe    (gp_a_oe),
        .gp_c_out   (gp_c_out),
        .gp_c_oe    (gp_c_oe),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe),
        .ahi_out    (ahi_out),
        .ahi_oe     (ahi_oe)
    );

    assign sel_regs  = idle_req && (region == RG_REGS);
    assign sel_io    = idle_req && (region == RG_IO);
    assign sel_sram  = idle_req && (region == RG_SRAM);
    assign bus_ready = (idle_req && !start) || last;
    assign bus_rdata = (last && !cmd_we) ? ad_in : '0;

    // R8: shared port floats while the read strobe is low
    p_read_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (ad_oe == '0));

    // R7: write strobe only with the port driven
    p_write_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (ad_oe == '1));

    // R6: high address held from address phase into data phase
    p_hi_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> ($stable(ahi_out) && ahi_oe == '1));

    // R2: internal selects never coincide with external signalling
    p_int_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_regs || sel_io || sel_sram) |-> (!ale && rd_n && wr_n && bus_ready));

    // R2: at most one select
    p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_regs, sel_io, sel_sram}));

endmodule

// File: tb/xmem_bridge_bench.sv
module xmem_bridge_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_ready, sel_regs, sel_io, sel_sram;
    logic        xmem_enable = 1'b0, xmem_wait = 1'b0;
    logic [7:0]  gp_a_out = '0, gp_a_oe = '0, gp_c_out = '0, gp_c_oe = '0;
    logic [7:0]  ad_out, ad_oe, ad_in, ahi_out, ahi_oe;
    logic        ale, rd_n, wr_n;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [7:0] ext_mem [0:1023];
    logic [7:0] exp_mem [0:1023];
    logic [7:0] lat = '0;
    logic [9:0] mem_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    xmem_bridge u_xmem_bridge (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .sel_regs(sel_regs), .sel_io(sel_io), .sel_sram(sel_sram),
        .xmem_enable(xmem_enable), .xmem_wait(xmem_wait),
        .gp_a_out(gp_a_out), .gp_a_oe(gp_a_oe), .gp_c_out(gp_c_out), .gp_c_oe(gp_c_oe),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .ahi_out(ahi_out), .ahi_oe(ahi_oe),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
    );

    // Behavioural address latch and memory on the pins
    assign mem_idx = {ahi_out[1:0], lat};
    assign ad_in   = !rd_n ? ext_mem[mem_idx] : 8'h00;

    always @(posedge clk) begin
        if (ale) lat <= ad_out;
        if (!wr_n) ext_mem[mem_idx] <= ad_out;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            fails = fails + 1;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // 0 regs, 1 io, 2 sram, 3 external
    function automatic int exp_region(input logic [15:0] a);
        if (a < 16'h0020) return 0;
        if (a < 16'h0060) return 1;
        if (a < 16'h0160) return 2;
        return 3;
    endfunction

    task automatic access(input logic [15:0] a, input bit we, input logic [7:0] wd,
                          input bit ws, input bit en);
        int rg;
        bit ext;
        rg  = exp_region(a);
        ext = (rg == 3) && en;
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = wd;
        xmem_wait = ws; xmem_enable = en; bus_req = 1'b1;
        #1;
        if (!ext) begin
            chk(bus_ready == 1'b1, "R2", "internal ready", bus_ready, 1);
            chk({sel_regs, sel_io, sel_sram} == (rg == 0 ? 3'b100 : rg == 1 ? 3'b010 :
                 rg == 2 ? 3'b001 : 3'b000), "R2", "select", {sel_regs, sel_io, sel_sram}, rg);
            chk(!ale && rd_n && wr_n, "R3", "no external cycle", {ale, rd_n, wr_n}, 3'b011);
            if (rg == 3) chk(bus_rdata == 8'h00, "R4", "disabled rdata", bus_rdata, 0);
            bus_req = 1'b0;
            return;
        end
        chk(bus_ready == 1'b0, "R10", "ready at accept", bus_ready, 0);
        @(negedge clk); #1;
        chk(ale == 1'b1, "R5", "ale in address phase", ale, 1);
        chk(ad_out == a[7:0] && ad_oe == 8'hFF, "R5", "low address", ad_out, a[7:0]);
        chk(ahi_out == a[15:8] && ahi_oe == 8'hFF, "R6", "high address", ahi_out, a[15:8]);
        chk(bus_ready == 1'b0, "R10", "ready in address phase", bus_ready, 0);
        @(negedge clk); #1;
        chk(ale == 1'b0, "R5", "ale single", ale, 0);
        chk(ahi_out == a[15:8], "R6", "high address in data", ahi_out, a[15:8]);
        if (we) begin
            chk(!wr_n && rd_n, "R7", "write strobes", {rd_n, wr_n}, 2'b10);
            chk(ad_out == wd && ad_oe == 8'hFF, "R7", "write data", ad_out, wd);
        end else begin
            chk(!rd_n && wr_n, "R8", "read strobes", {rd_n, wr_n}, 2'b01);
            chk(ad_oe == 8'h00, "R8", "port floats", ad_oe, 0);
        end
        chk(bus_ready == !ws, "R9", "ready in first data cycle", bus_ready, !ws);
        if (ws) begin
            @(negedge clk); #1;
            chk(we ? !wr_n : !rd_n, "R9", "strobe held in stretch", {rd_n, wr_n}, 0);
            chk(ahi_out == a[15:8], "R6", "high address in stretch", ahi_out, a[15:8]);
            chk(bus_ready == 1'b1, "R9", "ready after stretch", bus_ready, 1);
        end
        if (!we) chk(bus_rdata == exp_mem[a[9:0]], "R8", "read data", bus_rdata, exp_mem[a[9:0]]);
        bus_req = 1'b0;
        @(negedge clk); #1;
        chk(rd_n && wr_n && !bus_ready, "R10", "released after ready",
            {rd_n, wr_n, bus_ready}, 3'b110);
        if (we) begin
            exp_mem[a[9:0]] = wd;
            chk(ext_mem[a[9:0]] == wd, "R7", "memory written", ext_mem[a[9:0]], wd);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 1024; i++) begin
            ext_mem[i] = 8'h00;
            exp_mem[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        #1;
        chk(!ale && rd_n && wr_n && !bus_ready, "R1", "reset state",
            {ale, rd_n, wr_n, bus_ready}, 4'b0110);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!ale && rd_n && wr_n && !bus_ready, "R1", "idle after reset",
            {ale, rd_n, wr_n, bus_ready}, 4'b0110);

        // R4: general I/O pass-through when external mode is off
        gp_a_out = 8'hA5; gp_a_oe = 8'h3C; gp_c_out = 8'h5A; gp_c_oe = 8'hC3;
        xmem_enable = 1'b0;
        #1;
        chk(ad_out == 8'hA5 && ad_oe == 8'h3C, "R4", "port A pass", ad_out, 8'hA5);
        chk(ahi_out == 8'h5A && ahi_oe == 8'hC3, "R4", "port C pass", ahi_out, 8'h5A);
        access(16'h0200, 1'b1, 8'h77, 1'b0, 1'b0);
        @(negedge clk); #1;
        chk(ext_mem[10'h200] == 8'h00, "R4", "no write when disabled", ext_mem[10'h200], 0);

        // R2 / R3 boundaries
        access(16'h001F, 1'b0, 8'h00, 1'b0, 1'b1);
        access(16'h0020, 1'b0, 8'h00, 1'b0, 1'b1);
        access(16'h005F, 1'b1, 8'h11, 1'b0, 1'b1);
        access(16'h0060, 1'b0, 8'h00, 1'b0, 1'b1);
        access(16'h015F, 1'b1, 8'h22, 1'b1, 1'b1);
        access(16'h0160, 1'b1, 8'h3C, 1'b0, 1'b1);
        access(16'h0160, 1'b0, 8'h00, 1'b1, 1'b1);
        access(16'hFFFF, 1'b1, 8'hC9, 1'b1, 1'b1);
        access(16'hFFFF, 1'b0, 8'h00, 1'b0, 1'b1);

        // Random mix
        for (int i = 0; i < 300; i++) begin
            logic [15:0] a;
            int cls;
            cls = $urandom % 4;
            unique case (cls)
                0: a = 16'($urandom % 32);
                1: a = 16'h20 + 16'($urandom % 64);
                2: a = 16'h60 + 16'($urandom % 256);
                default: a = 16'h160 + 16'($urandom % 16'h2A0);
            endcase
            access(a, 1'($urandom), 8'($urandom), 1'($urandom), ($urandom % 8) != 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule